// File: doc/BRIEF.md
# Non-Restoring Sequential Unsigned Divider

This block divides an unsigned W-bit dividend by an unsigned W-bit divisor over several clock cycles and returns a W-bit quotient and a W-bit remainder. A partial remainder register of W+1 bits works alongside a quotient register and a divisor register. Each iteration shifts the partial remainder and the quotient left by one bit. The sign of the partial remainder from the previous step then decides whether the divisor is added or subtracted. Because of this, the partial remainder never has to be restored inside the loop. One extra cycle corrects the remainder only when the last iteration leaves it negative.

A caller presents both operands with a one-cycle `start` while the block is idle. It then waits for the one-cycle `done` pulse, and results stay on the outputs until the next accepted start. A zero divisor skips the iterations. It reports `div_zero`, returns an all-ones quotient and passes the dividend through as the remainder.

The controller has four states. `S_IDLE` waits for a start. `S_ITER` performs one shift-and-add/subtract per cycle. `S_FIX` adds the divisor back into a negative final remainder. `S_DONE` raises `done` for one cycle. The transitions are:
- `S_IDLE` to `S_ITER` on a start with a non-zero divisor.
- `S_IDLE` to `S_DONE` on a start with a zero divisor.
- `S_ITER` to itself until the W-th iteration.
- `S_ITER` to `S_FIX` when the W-th iteration leaves a negative partial remainder.
- `S_ITER` to `S_DONE` when the W-th iteration leaves a non-negative partial remainder.
- `S_FIX` to `S_DONE` unconditionally.
- `S_DONE` to `S_IDLE` unconditionally.

Top module: `seq_nr_divider`

## Requirements
- R1: While reset is asserted and after its release, before any start, `busy`, `done` and `div_zero` are 0 and `quotient` and `remainder` are 0.
- R2: A start is taken only while `busy` is 0; a start raised while `busy` is 1 does not change the operation in progress nor its results, and `busy` stays 1 until that operation's `done`.
- R3: With a non-zero divisor, at `done` the quotient equals floor(dividend/divisor), the remainder equals dividend mod divisor, quotient*divisor+remainder equals the dividend and the remainder is less than the divisor.
- R4: With a non-zero divisor, `done` is high W+1 cycles after the clock edge that takes the start when the final partial remainder is non-negative, and W+2 cycles after it when a correction step is needed.
- R5: `done` is high for exactly one cycle per accepted start; `busy` is 1 from the cycle after the accepted start up to and including the `done` cycle, and 0 in the cycle after.
- R6: With a zero divisor, `done` is high one cycle after the accepting edge, `div_zero` is 1, `quotient` is all ones and `remainder` equals the dividend.
- R7: `div_zero` returns to 0 at the next accepted start with a non-zero divisor.
- R8: While `busy` is 0 and no start is given, `quotient`, `remainder` and `div_zero` keep their values whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a division, taken when idle |
| dividend | input | W | Unsigned dividend, sampled with an accepted start |
| divisor | input | W | Unsigned divisor, sampled with an accepted start |
| busy | output | 1 | An operation is in progress (including its done cycle) |
| done | output | 1 | One-cycle pulse: results are valid |
| div_zero | output | 1 | The last accepted operation had a zero divisor |
| quotient | output | W | Quotient result |
| remainder | output | W | Remainder result |

## Verification
On every cycle, the assertions check the following:
- `done` is a single-cycle pulse inside `busy`, and an operation cannot be dropped mid-run.
- The latency counted since the accepting edge is one of the three legal values.
- Results are rebuilt from operands captured at the accepting edge, so quotient*divisor+remainder must equal the dividend and the remainder must be smaller than the divisor.
- Zero-divisor results are all-ones and pass-through, and idle outputs stay stable.

Only the bench's scenarios can show several things. The first is which of the two latencies a given operand pair must take, which needs a reference stepping of the algorithm. The bench also shows that a start poked mid-run leaves the results untouched, that `div_zero` clears on the following division, and that extreme operands give exact values: zero dividend, divisor one, equal operands, a divisor larger than the dividend, and all-ones inputs.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_ITER = 2'd1,
        S_FIX  = 2'd2,
        S_DONE = 2'd3
    } nr_state_e;
endpackage

// File: rtl/nrdiv_addsub.sv
// (W+1)-bit adder/subtractor: sum = a + b or a - b (two's complement).
module nrdiv_addsub #(
    parameter int W = 16
) (
    input  logic [W:0] op_a,
    input  logic [W:0] op_b,
    input  logic       sub,
    output logic [W:0] sum
);
    logic [W:0] b_eff;

    always_comb begin
        b_eff = op_b ^ {(W+1){sub}};
        sum   = op_a + b_eff + {{W{1'b0}}, sub};
    end
endmodule

// File: rtl/nrdiv_datapath.sv
// Partial remainder A (W+1 bits), quotient Q and divisor M registers.
module nrdiv_datapath #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         zload,
    input  logic         step,
    input  logic         fix,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         step_neg,
    output logic         div_zero,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);
    logic [W:0]   a_q;
    logic [W-1:0] q_q;
    logic [W-1:0] m_q;
    logic         dz_q;
    logic [W:0]   shifted;
    logic [W:0]   op_a;
    logic         sub;
    logic [W:0]   sum;

    always_comb begin
        shifted = {a_q[W-1:0], q_q[W-1]};
        op_a    = fix ? a_q : shifted;
        // previous sign 0 -> subtract, 1 -> add; correction always adds
        sub     = fix ? 1'b0 : ~a_q[W];
    end

    nrdiv_addsub #(.W(W)) u_addsub (
        .op_a (op_a),
        .op_b ({1'b0, m_q}),
        .sub  (sub),
        .sum  (sum)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q  <= '0;
            q_q  <= '0;
            m_q  <= '0;
            dz_q <= 1'b0;
        end else if (load) begin
            a_q  <= '0;
            q_q  <= dividend;
            m_q  <= divisor;
            dz_q <= 1'b0;
        end else if (zload) begin
            a_q  <= {1'b0, dividend};
            q_q  <= '1;
            m_q  <= divisor;
            dz_q <= 1'b1;
        end else if (step) begin
            a_q  <= sum;
            q_q  <= {q_q[W-2:0], ~sum[W]};
        end else if (fix) begin
            a_q  <= sum;
        end
    end

    assign step_neg  = sum[W];
    assign div_zero  = dz_q;
    assign quotient  = q_q;
    assign remainder = a_q[W-1:0];
endmodule

// File: rtl/nrdiv_ctrl.sv
// Sequencer: idle, W iterations, optional correction, done pulse.
module nrdiv_ctrl
    import nrdiv_pkg::*;
#(
    parameter int W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic divisor_zero,
    input  logic step_neg,
    output logic load,
    output logic zload,
    output logic step,
    output logic fix,
    output logic busy,
    output logic done
);
    localparam int CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    nr_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt_q <= '0;
        else if (load)      cnt_q <= '0;
        else if (step)      cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start) state_d = divisor_zero ? S_DONE : S_ITER;
            S_ITER: if (cnt_q == LAST) state_d = step_neg ? S_FIX : S_DONE;
            S_FIX:  state_d = S_DONE;
            S_DONE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        load  = 1'b0;
        zload = 1'b0;
        step  = 1'b0;
        fix   = 1'b0;
        busy  = 1'b1;
        done  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                busy  = 1'b0;
                load  = start & ~divisor_zero;
                zload = start & divisor_zero;
            end
            S_ITER: step = 1'b1;
            S_FIX:  fix  = 1'b1;
            S_DONE: done = 1'b1;
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/seq_nr_divider.sv
module seq_nr_divider #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic         div_zero,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);
    logic load, zload, step, fix, step_neg, divisor_zero;

    assign divisor_zero = (divisor == '0);

    nrdiv_ctrl #(.W(W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .divisor_zero (divisor_zero),
        .step_neg     (step_neg),
        .load         (load),
        .zload        (zload),
        .step         (step),
        .fix          (fix),
        .busy         (busy),
        .done         (done)
    );

    nrdiv_datapath #(.W(W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .zload     (zload),
        .step      (step),
        .fix       (fix),
        .dividend  (dividend),
        .divisor   (divisor),
        .step_neg  (step_neg),
        .div_zero  (div_zero),
        .quotient  (quotient),
        .remainder (remainder)
    );
endmodule

// File: rtl/nrdiv_chk.sv
module nrdiv_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] dividend,
    input logic [W-1:0] divisor,
    input logic         busy,
    input logic         done,
    input logic         div_zero,
    input logic [W-1:0] quotient,
    input logic [W-1:0] remainder
);
    logic [W-1:0]   sh_n, sh_d;
    logic [15:0]    lat;
    logic [2*W-1:0] recon;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_n <= '0;
            sh_d <= '0;
            lat  <= '0;
        end else if (start && !busy) begin
            sh_n <= dividend;
            sh_d <= divisor;
            lat  <= '0;
        end else if (busy) begin
            lat  <= lat + 16'd1;
        end
    end

    always_comb recon = ((2*W)'(quotient) * (2*W)'(sh_d)) + (2*W)'(remainder);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R5
    AST_NO_EARLY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R2
    AST_RESULT_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero) |-> (recon == (2*W)'(sh_n) && remainder < sh_d)); // R3
    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero) |-> (lat == 16'(W) || lat == 16'(W + 1))); // R4
    AST_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_zero) |-> (quotient == '1 && remainder == sh_n && lat == 16'd0)); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(div_zero))); // R8
endmodule

bind seq_nr_divider nrdiv_chk #(.W(W)) u_nrdiv_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dividend  (dividend),
    .divisor   (divisor),
    .busy      (busy),
    .done      (done),
    .div_zero  (div_zero),
    .quotient  (quotient),
    .remainder (remainder)
);

// File: tb/test_seq_nr_divider.sv
`timescale 1ns/1ps
module test_seq_nr_divider;
    localparam int W = 16;
    localparam longint MASK = (64'd1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy, done, div_zero;
    logic [W-1:0] quotient, remainder;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    seq_nr_divider #(.W(W)) i_seq_nr_divider (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .div_zero(div_zero),
        .quotient(quotient), .remainder(remainder)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural model of the iteration: does the last step leave a negative remainder?
    function automatic bit needs_fix(input longint n, input longint d);
        longint a = 0;
        longint q = n;
        for (int i = 0; i < W; i++) begin
            longint qm = (q >> (W - 1)) & 1;
            q = (q << 1) & MASK;
            if (a >= 0) a = 2 * a + qm - d;
            else        a = 2 * a + qm + d;
            if (a >= 0) q = q | 1;
        end
        return a < 0;
    endfunction

    task automatic run_div(input longint n, input longint d, input bit poke);
        int L;
        longint eq, er;
        if (d == 0) begin
            L = 1; eq = MASK; er = n;
        end else begin
            L = needs_fix(n, d) ? W + 2 : W + 1;
            eq = n / d; er = n % d;
        end
        @(negedge clk);
        dividend = W'(n); divisor = W'(d); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k <= L + 1; k++) begin
            bit eb = (k <= L);
            bit ed = (k == L);
            chk(busy == eb, "R5 busy", busy, eb);
            chk(done == ed, "R4 done timing", done, ed);
            if (k == L) begin
                chk(div_zero == (d == 0), "R6/R7 div_zero", div_zero, (d == 0));
                chk(quotient == W'(eq), d == 0 ? "R6 quotient" : "R3 quotient", quotient, eq);
                chk(remainder == W'(er), d == 0 ? "R6 remainder" : "R3 remainder", remainder, er);
                if (d != 0) begin
                    longint rc = longint'(quotient) * d + longint'(remainder);
                    chk(rc == n && longint'(remainder) < d, "R3 identity", rc, n);
                end
            end
            if (poke && k == 3) begin
                // R2: a start while busy must be ignored
                start = 1'b1; dividend = ~W'(n); divisor = W'(d + 3);
            end else begin
                start = 1'b0;
            end
            if (k <= L) @(negedge clk);
        end
        start = 1'b0;
    endtask

    task automatic hold_check;
        logic [W-1:0] q0 = quotient;
        logic [W-1:0] r0 = remainder;
        logic         z0 = div_zero;
        for (int i = 0; i < 3; i++) begin
            dividend = W'(i * 977 + 5); divisor = W'(i);
            @(negedge clk);
            chk(quotient == q0 && remainder == r0 && div_zero == z0 && !busy,
                "R8 hold", {quotient, remainder}, {q0, r0});
        end
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !div_zero, "R1 flags in reset", {busy, done, div_zero}, 0);
        chk(quotient == 0 && remainder == 0, "R1 results in reset", {quotient, remainder}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !div_zero, "R1 flags after reset", {busy, done, div_zero}, 0);

        run_div(100, 7, 0);          // R3
        run_div(0, 5, 0);            // R3 zero dividend
        run_div(65535, 1, 0);        // R3 divisor one
        run_div(65535, 65535, 0);    // R3 equal operands
        run_div(5, 9, 0);            // R3 divisor larger
        run_div(65535, 2, 0);        // R4
        run_div(12345, 0, 0);        // R6 zero divisor
        hold_check();                // R8
        run_div(20, 3, 0);           // R7 div_zero cleared
        run_div(40000, 123, 1);      // R2 start while busy ignored
        hold_check();                // R8
        run_div(65535, 0, 1);        // R6 with all-ones dividend
        run_div(32768, 32767, 0);    // R4
        for (int i = 0; i < 150; i++) begin
            longint n = longint'($urandom) & MASK;
            longint d = longint'($urandom) & ((i % 3 == 0) ? 64'hFF : MASK);
            run_div(n, d, (i % 10) == 4);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule